// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block caches recent page-to-frame translations so that most address lookups avoid a page-table walk. It is fully associative. Each entry holds an owner process tag, a virtual page number, a physical frame number and three attribute bits: present, read-only and no-execute. A lookup presents the current process tag, a page number and an access kind. It hits only when some entry matches both the tag and the page. Entries owned by other processes stay resident, so a process switch needs no full invalidation.

On a hit, the frame number or a fault code appears one cycle after the request is accepted. On a miss, the block stalls the requester and raises a refill request that carries the pending tag and page. An external walker answers with the translation. The block installs that translation and responds in the next cycle. Replacement uses the lowest-numbered free slot when one exists, and a round-robin pointer otherwise. Two invalidation inputs are provided. One clears every entry and is used when the page-table base changes. The other clears only the entries owned by one process tag. Free-running hit and miss counters let the hit ratio be observed.

Top module: `tlb_xlate`

## Requirements
- R1: A request accepted while `busy_o` is low, whose tag and page match a stored entry, raises `rsp_valid_o` in the next cycle with that entry's frame and without raising `refill_req_o`.
- R2: A request that matches no entry raises `busy_o` and `refill_req_o` from the next cycle onward. While no refill is supplied, both stay high and `refill_tag_o`/`refill_vpn_o` hold the requested tag and page.
- R3: A refill arriving while waiting raises `rsp_valid_o` in the next cycle with the refilled result and drops `busy_o`. The installed translation then hits on later requests.
- R4: An entry never hits for a request whose tag differs from the entry's owner tag, even when the page number matches.
- R5: A pulse on `flush_all_i` invalidates every entry and returns the round-robin pointer to slot 0.
- R6: A pulse on `flush_tag_en_i` invalidates only the entries whose owner tag equals `flush_tag_i`. Entries with other tags keep hitting.
- R7: Access kind is encoded on `req_kind_i` as 0 = load, 1 = store, 2 = fetch, with 3 treated as a load. A store to a read-only page gives `rsp_cause_o` = 2, while a load to the same page succeeds.
- R8: A fetch from a no-execute page gives `rsp_cause_o` = 3, while a load to the same page succeeds.
- R9: A translation whose present bit is clear gives `rsp_cause_o` = 1. The cause codes are 0 = none, 1 = absent, 2 = write to read-only, 3 = fetch from no-execute, and absent takes priority over the others. Such a translation is still cached, so a repeat request hits and faults again. Whenever the cause is nonzero, `rsp_fault_o` is high and `rsp_pfn_o` is 0.
- R10: An install goes to the lowest-numbered invalid slot whenever any slot is invalid.
- R11: When all slots are valid, installs replace slots in round-robin order 0, 1, 2, ... The pointer advances only on such replacements.
- R12: `hit_count_o` and `miss_count_o` start at 0 after reset and each increment by one per accepted hit or miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request, accepted when `busy_o` is low |
| req_tag_i | input | TAG_W | Current process tag |
| req_vpn_i | input | VPN_W | Virtual page number |
| req_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| busy_o | output | 1 | Requester stalled waiting for a refill |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_pfn_o | output | PFN_W | Frame number; 0 when faulting |
| rsp_fault_o | output | 1 | Response is a fault |
| rsp_cause_o | output | 2 | Fault cause code |
| refill_req_o | output | 1 | Walk request to the external walker |
| refill_tag_o | output | TAG_W | Tag of the pending miss |
| refill_vpn_o | output | VPN_W | Page of the pending miss |
| refill_valid_i | input | 1 | Walker result strobe |
| refill_pfn_i | input | PFN_W | Walked frame number |
| refill_present_i | input | 1 | Walked present bit |
| refill_ro_i | input | 1 | Walked read-only bit |
| refill_nx_i | input | 1 | Walked no-execute bit |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_tag_en_i | input | 1 | Invalidate entries of one tag |
| flush_tag_i | input | TAG_W | Tag to invalidate |
| hit_count_o | output | CNT_W | Accepted hits |
| miss_count_o | output | CNT_W | Accepted misses |

## Verification
The bench uses the default parameters: 8 entries, 8-bit tags, 20-bit pages, 24-bit frames and 16-bit counters. With only eight slots, a handful of misses fills the array. The bench can then force both the free-slot-first choice, after a per-tag flush opens a hole, and the wrap of the round-robin pointer. Eviction order is observed purely through which pages miss afterwards. Eight-bit tags leave room for two processes that share page numbers, which exercises tag isolation and selective invalidation.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_WPROT  = 2'd2,
    FLT_NOEXEC = 2'd3
  } fault_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } tlb_state_e;

  // absent outranks permission faults
  function automatic fault_e fault_of(input logic present, input logic ro,
                                      input logic nx, input logic [1:0] kind);
    if (!present) return FLT_ABSENT;
    if (kind == ACC_STORE && ro) return FLT_WPROT;
    if (kind == ACC_FETCH && nx) return FLT_NOEXEC;
    return FLT_NONE;
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 24,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TAG_W-1:0]   lk_tag_i,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  output logic               hit_o,
  output logic [PFN_W-1:0]   hit_pfn_o,
  output logic               hit_present_o,
  output logic               hit_ro_o,
  output logic               hit_nx_o,
  output logic [ENTRIES-1:0] valid_o,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [PFN_W-1:0]   wr_pfn_i,
  input  logic               wr_present_i,
  input  logic               wr_ro_i,
  input  logic               wr_nx_i,
  input  logic               flush_all_i,
  input  logic               flush_tag_en_i,
  input  logic [TAG_W-1:0]   flush_tag_i
);
  logic [ENTRIES-1:0]            match;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_v;
  logic [ENTRIES-1:0]            pres_v, ro_v, nx_v;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic             vld_q;
    logic [TAG_W-1:0] tag_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PFN_W-1:0] pfn_q;
    logic             pres_q, ro_q, nx_q;
    logic             kill, load;

    assign kill = flush_all_i || (flush_tag_en_i && tag_q == flush_tag_i);
    assign load = wr_en_i && wr_idx_i == IDX_W'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        tag_q  <= '0;
        vpn_q  <= '0;
        pfn_q  <= '0;
        pres_q <= 1'b0;
        ro_q   <= 1'b0;
        nx_q   <= 1'b0;
      end else begin
        if (kill) vld_q <= 1'b0;
        if (load) begin
          vld_q  <= 1'b1;
          tag_q  <= wr_tag_i;
          vpn_q  <= wr_vpn_i;
          pfn_q  <= wr_pfn_i;
          pres_q <= wr_present_i;
          ro_q   <= wr_ro_i;
          nx_q   <= wr_nx_i;
        end
      end
    end

    assign match[i]  = vld_q && tag_q == lk_tag_i && vpn_q == lk_vpn_i;
    assign valid_o[i] = vld_q;
    assign pfn_v[i]  = pfn_q;
    assign pres_v[i] = pres_q;
    assign ro_v[i]   = ro_q;
    assign nx_v[i]   = nx_q;

    assert_tag_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_tag_en_i && tag_q == flush_tag_i && !load) |=> !vld_q);
  end

  // one-hot match: AND-OR readout
  always_comb begin
    hit_pfn_o     = '0;
    hit_present_o = 1'b0;
    hit_ro_o      = 1'b0;
    hit_nx_o      = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_pfn_o     = hit_pfn_o | pfn_v[i];
        hit_present_o = hit_present_o | pres_v[i];
        hit_ro_o      = hit_ro_o | ro_v[i];
        hit_nx_o      = hit_nx_o | nx_v[i];
      end
    end
  end

  assign hit_o = |match;

  assert_single_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  assert_flush_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i && !wr_en_i) |=> valid_o == '0);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               alloc_i,
  input  logic               restart_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             full;

  assign full = &valid_i;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim_o = full ? ptr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (restart_i) ptr_q <= '0;
    else if (alloc_i && full)
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  assert_invalid_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !full) |-> !valid_i[victim_o]);

  assert_rr_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_i && !restart_i) |=> $stable(ptr_q));
endmodule

// File: rtl/tlb_perf_ctr.sv
module tlb_perf_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_inc_i,
  input  logic             miss_inc_i,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else begin
      if (hit_inc_i)  hit_cnt_o  <= hit_cnt_o + 1'b1;
      if (miss_inc_i) miss_cnt_o <= miss_cnt_o + 1'b1;
    end
  end

  assert_count_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_inc_i && !miss_inc_i) |=> ($stable(hit_cnt_o) && $stable(miss_cnt_o)));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 24,
  parameter int CNT_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [1:0]       req_kind_i,
  output logic             busy_o,
  output logic             rsp_valid_o,
  output logic [PFN_W-1:0] rsp_pfn_o,
  output logic             rsp_fault_o,
  output logic [1:0]       rsp_cause_o,
  output logic             refill_req_o,
  output logic [TAG_W-1:0] refill_tag_o,
  output logic [VPN_W-1:0] refill_vpn_o,
  input  logic             refill_valid_i,
  input  logic [PFN_W-1:0] refill_pfn_i,
  input  logic             refill_present_i,
  input  logic             refill_ro_i,
  input  logic             refill_nx_i,
  input  logic             flush_all_i,
  input  logic             flush_tag_en_i,
  input  logic [TAG_W-1:0] flush_tag_i,
  output logic [CNT_W-1:0] hit_count_o,
  output logic [CNT_W-1:0] miss_count_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  tlb_state_e       state_q;
  logic [TAG_W-1:0] pend_tag_q;
  logic [VPN_W-1:0] pend_vpn_q;
  logic [1:0]       pend_kind_q;
  logic             rsp_valid_q;
  logic [PFN_W-1:0] rsp_pfn_q;
  fault_e           rsp_cause_q;

  logic               hit;
  logic [PFN_W-1:0]   hit_pfn;
  logic               hit_present, hit_ro, hit_nx;
  logic [ENTRIES-1:0] valid;
  logic [IDX_W-1:0]   victim;
  logic               accept, acc_hit, acc_miss, install;
  fault_e             hit_cause, fill_cause;

  assign accept   = state_q == ST_IDLE && req_valid_i;
  assign acc_hit  = accept && hit;
  assign acc_miss = accept && !hit;
  assign install  = state_q == ST_WAIT && refill_valid_i;

  tlb_entry_array #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_array (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lk_tag_i      (req_tag_i),
    .lk_vpn_i      (req_vpn_i),
    .hit_o         (hit),
    .hit_pfn_o     (hit_pfn),
    .hit_present_o (hit_present),
    .hit_ro_o      (hit_ro),
    .hit_nx_o      (hit_nx),
    .valid_o       (valid),
    .wr_en_i       (install),
    .wr_idx_i      (victim),
    .wr_tag_i      (pend_tag_q),
    .wr_vpn_i      (pend_vpn_q),
    .wr_pfn_i      (refill_pfn_i),
    .wr_present_i  (refill_present_i),
    .wr_ro_i       (refill_ro_i),
    .wr_nx_i       (refill_nx_i),
    .flush_all_i   (flush_all_i),
    .flush_tag_en_i(flush_tag_en_i),
    .flush_tag_i   (flush_tag_i)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid),
    .alloc_i  (install),
    .restart_i(flush_all_i),
    .victim_o (victim)
  );

  tlb_perf_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_inc_i (acc_hit),
    .miss_inc_i(acc_miss),
    .hit_cnt_o (hit_count_o),
    .miss_cnt_o(miss_count_o)
  );

  assign hit_cause  = fault_of(hit_present, hit_ro, hit_nx, req_kind_i);
  assign fill_cause = fault_of(refill_present_i, refill_ro_i, refill_nx_i, pend_kind_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_tag_q  <= '0;
      pend_vpn_q  <= '0;
      pend_kind_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_pfn_q   <= '0;
      rsp_cause_q <= FLT_NONE;
    end else begin
      rsp_valid_q <= acc_hit || install;
      if (acc_hit) begin
        rsp_cause_q <= hit_cause;
        rsp_pfn_q   <= (hit_cause == FLT_NONE) ? hit_pfn : '0;
      end else if (install) begin
        rsp_cause_q <= fill_cause;
        rsp_pfn_q   <= (fill_cause == FLT_NONE) ? refill_pfn_i : '0;
      end
      if (acc_miss) begin
        state_q     <= ST_WAIT;
        pend_tag_q  <= req_tag_i;
        pend_vpn_q  <= req_vpn_i;
        pend_kind_q <= req_kind_i;
      end else if (install) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign busy_o       = state_q == ST_WAIT;
  assign refill_req_o = state_q == ST_WAIT;
  assign refill_tag_o = pend_tag_q;
  assign refill_vpn_o = pend_vpn_q;
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_pfn_o    = rsp_pfn_q;
  assign rsp_cause_o  = rsp_cause_q;
  assign rsp_fault_o  = rsp_cause_q != FLT_NONE;

  assert_hit_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit) |=> (rsp_valid_o && !busy_o));

  assert_miss_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !refill_valid_i) |=>
      (busy_o && !rsp_valid_o && $stable(refill_tag_o) && $stable(refill_vpn_o)));

  assert_refill_rsp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && refill_valid_i) |=> (rsp_valid_o && !busy_o));

  assert_fault_no_pfn_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> rsp_pfn_o == '0);
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [7:0]  req_tag_i = '0;
  logic [19:0] req_vpn_i = '0;
  logic [1:0]  req_kind_i = '0;
  logic        busy_o, rsp_valid_o, rsp_fault_o, refill_req_o;
  logic [23:0] rsp_pfn_o;
  logic [1:0]  rsp_cause_o;
  logic [7:0]  refill_tag_o;
  logic [19:0] refill_vpn_o;
  logic        refill_valid_i = 1'b0;
  logic [23:0] refill_pfn_i = '0;
  logic        refill_present_i = 1'b0, refill_ro_i = 1'b0, refill_nx_i = 1'b0;
  logic        flush_all_i = 1'b0, flush_tag_en_i = 1'b0;
  logic [7:0]  flush_tag_i = '0;
  logic [15:0] hit_count_o, miss_count_o;

  int checks = 0, fails = 0, exp_hits = 0, exp_miss = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tlb_xlate uut (.*);

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic flush_all();
    @(negedge clk_i); flush_all_i = 1'b1;
    @(negedge clk_i); flush_all_i = 1'b0;
  endtask

  task automatic flush_tag(input logic [7:0] t);
    @(negedge clk_i); flush_tag_en_i = 1'b1; flush_tag_i = t;
    @(negedge clk_i); flush_tag_en_i = 1'b0;
  endtask

  // one request; on a miss plays the walker with the given data
  task automatic lookup(input logic [7:0] tag, input logic [19:0] vpn, input logic [1:0] kind,
                        input bit exp_hit, input logic [23:0] pfn, input bit pr, input bit ro,
                        input bit nx, input logic [1:0] exp_cause, input string rq);
    logic [23:0] exp_pfn;
    exp_pfn = (exp_cause == 2'd0) ? pfn : 24'd0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_tag_i = tag; req_vpn_i = vpn; req_kind_i = kind;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (exp_hit) begin
      exp_hits++;
      chk(refill_req_o == 1'b0, {rq, " R1 no refill on hit"}, refill_req_o, 0);
      chk(rsp_valid_o == 1'b1, {rq, " R1 hit latency"}, rsp_valid_o, 1);
    end else begin
      exp_miss++;
      chk(rsp_valid_o == 1'b0, {rq, " R2 no response on miss"}, rsp_valid_o, 0);
      chk(refill_req_o == 1'b1 && refill_tag_o == tag && refill_vpn_o == vpn,
          {rq, " R2 refill request"}, {refill_req_o, refill_tag_o, refill_vpn_o}, {1'b1, tag, vpn});
      repeat (2) @(negedge clk_i);
      chk(busy_o == 1'b1 && refill_vpn_o == vpn, {rq, " R2 stall held"}, busy_o, 1);
      refill_valid_i = 1'b1; refill_pfn_i = pfn;
      refill_present_i = pr; refill_ro_i = ro; refill_nx_i = nx;
      @(negedge clk_i);
      refill_valid_i = 1'b0;
      chk(rsp_valid_o == 1'b1 && busy_o == 1'b0, {rq, " R3 refill response"},
          {rsp_valid_o, busy_o}, 2'b10);
    end
    chk(rsp_pfn_o == exp_pfn, {rq, " pfn"}, rsp_pfn_o, exp_pfn);
    chk(rsp_cause_o == exp_cause && rsp_fault_o == (exp_cause != 0), {rq, " cause"},
        rsp_cause_o, exp_cause);
    chk(hit_count_o == 16'(exp_hits) && miss_count_o == 16'(exp_miss), {rq, " R12 counters"},
        {hit_count_o, miss_count_o}, {16'(exp_hits), 16'(exp_miss)});
  endtask

  task automatic t_reset();
    chk(rsp_valid_o == 0 && busy_o == 0 && refill_req_o == 0, "R2 reset idle",
        {rsp_valid_o, busy_o, refill_req_o}, 0);
    chk(hit_count_o == 0 && miss_count_o == 0, "R12 reset counters",
        {hit_count_o, miss_count_o}, 0);
  endtask

  task automatic t_miss_hit();
    flush_all();
    lookup(8'h01, 20'h00100, 2'd0, 0, 24'h000ABC, 1, 0, 0, 2'd0, "R3 first miss");
    lookup(8'h01, 20'h00100, 2'd0, 1, 24'h000ABC, 1, 0, 0, 2'd0, "R1 repeat hit");
  endtask

  task automatic t_tags();
    lookup(8'h02, 20'h00100, 2'd0, 0, 24'h000222, 1, 0, 0, 2'd0, "R4 other tag misses");
    lookup(8'h01, 20'h00100, 2'd0, 1, 24'h000ABC, 1, 0, 0, 2'd0, "R4 tag1 kept");
    lookup(8'h02, 20'h00100, 2'd0, 1, 24'h000222, 1, 0, 0, 2'd0, "R4 tag2 own frame");
  endtask

  task automatic t_protect();
    lookup(8'h01, 20'h00200, 2'd1, 0, 24'h000333, 1, 1, 0, 2'd2, "R7 store miss ro");
    lookup(8'h01, 20'h00200, 2'd0, 1, 24'h000333, 1, 1, 0, 2'd0, "R7 load ro ok");
    lookup(8'h01, 20'h00200, 2'd1, 1, 24'h000333, 1, 1, 0, 2'd2, "R7 store hit ro");
    lookup(8'h01, 20'h00300, 2'd0, 0, 24'h000444, 1, 0, 1, 2'd0, "R8 load nx ok");
    lookup(8'h01, 20'h00300, 2'd2, 1, 24'h000444, 1, 0, 1, 2'd3, "R8 fetch nx");
    lookup(8'h01, 20'h00300, 2'd1, 1, 24'h000444, 1, 0, 1, 2'd0, "R8 store nx ok");
  endtask

  task automatic t_absent();
    lookup(8'h01, 20'h00400, 2'd1, 0, 24'h000555, 0, 1, 1, 2'd1, "R9 absent miss");
    lookup(8'h01, 20'h00400, 2'd2, 1, 24'h000555, 0, 1, 1, 2'd1, "R9 absent cached");
  endtask

  task automatic t_flush_all();
    flush_all();
    lookup(8'h01, 20'h00100, 2'd0, 0, 24'h000ABD, 1, 0, 0, 2'd0, "R5 gone after flush");
    lookup(8'h02, 20'h00100, 2'd0, 0, 24'h000223, 1, 0, 0, 2'd0, "R5 tag2 gone");
  endtask

  task automatic t_flush_tag();
    flush_tag(8'h02);
    lookup(8'h01, 20'h00100, 2'd0, 1, 24'h000ABD, 1, 0, 0, 2'd0, "R6 other tag survives");
    lookup(8'h02, 20'h00100, 2'd0, 0, 24'h000224, 1, 0, 0, 2'd0, "R6 flushed tag misses");
  endtask

  task automatic t_invalid_first();
    flush_all();
    for (int i = 0; i < 7; i++)
      lookup(8'h01, 20'h00010 + 20'(i), 2'd0, 0, 24'h001000 + 24'(i), 1, 0, 0, 2'd0, "R10 fill");
    lookup(8'h02, 20'h00050, 2'd0, 0, 24'h002000, 1, 0, 0, 2'd0, "R10 fill slot7");
    flush_tag(8'h02);
    lookup(8'h01, 20'h00020, 2'd0, 0, 24'h003000, 1, 0, 0, 2'd0, "R10 refill into hole");
    for (int i = 0; i < 7; i++)
      lookup(8'h01, 20'h00010 + 20'(i), 2'd0, 1, 24'h001000 + 24'(i), 1, 0, 0, 2'd0,
             "R10 earlier pages kept");
  endtask

  task automatic t_round_robin();
    lookup(8'h01, 20'h00030, 2'd0, 0, 24'h004000, 1, 0, 0, 2'd0, "R11 replace slot0");
    lookup(8'h01, 20'h00011, 2'd0, 1, 24'h001001, 1, 0, 0, 2'd0, "R11 slot1 intact");
    lookup(8'h01, 20'h00010, 2'd0, 0, 24'h001000, 1, 0, 0, 2'd0, "R11 slot0 evicted");
    lookup(8'h01, 20'h00011, 2'd0, 0, 24'h001001, 1, 0, 0, 2'd0, "R11 slot1 evicted next");
    lookup(8'h01, 20'h00013, 2'd0, 1, 24'h001003, 1, 0, 0, 2'd0, "R11 slot3 intact");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_miss_hit();
    t_tags();
    t_protect();
    t_absent();
    t_flush_all();
    t_flush_tag();
    t_invalid_first();
    t_round_robin();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule